// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This unit divides a double-width dividend by a single-width divisor for a 32-bit processor pipeline. The dividend is built by placing the contents of the processor's auxiliary high-word register above the operand, and the divisor is a single word. A mode input selects unsigned or two's-complement signed division. The quotient is truncated toward zero. It is returned in a double-width result word: an in-range quotient is zero-extended, and an out-of-range quotient is clamped to the nearest representable bound, with the upper half filled with ones and an overflow flag raised.

A request is issued by pulsing `start` while the unit is idle. Operands and mode are captured at that edge. The unit then runs a restoring shift-subtract loop that produces one quotient bit per cycle, and pulses `done` for one cycle when the result is ready. A zero divisor is detected at the capture edge. The unit then reports a divide-by-zero trap on the next cycle and skips the loop. All outputs are registered and hold their value until the next completion.

Top module: `ydiv_sat_unit`

## Requirements
- R1: The dividend is {y_hi, opnd_lo} (y_hi in bits 63:32). In unsigned mode (signed_mode=0), a quotient that fits in 32 bits is returned as result = {32'h0, quotient} with overflow=0.
- R2: A divisor of zero captured with start makes done=1 on the next cycle with dz_trap=1, overflow=0 and result=0. busy never rises for that request.
- R3: In unsigned mode, a true quotient above 0xFFFFFFFF gives result = 64'hFFFFFFFF_FFFFFFFF and overflow=1.
- R4: In signed mode (signed_mode=1), the quotient truncates toward zero. A quotient within [-2^31, 2^31-1] is returned as its 32-bit two's-complement pattern, zero-extended to 64 bits, with overflow=0.
- R5: In signed mode, a quotient above 2^31-1 gives result = {32'hFFFFFFFF, 32'h7FFFFFFF}, and a quotient below -2^31 gives result = {32'hFFFFFFFF, 32'h80000000`}. overflow=1 in both cases.
- R6: In signed mode, a dividend of exactly 0x8000000000000000 always saturates with overflow=1. The low word is 0x7FFFFFFF when the divisor is negative and 0x80000000 otherwise.
- R7: For a nonzero divisor, busy is 1 from the edge that captures start until the completion edge. done is 1 for exactly the one cycle that follows the 65th rising edge after the capture edge, and busy is 0 during that cycle.
- R8: start is ignored while busy=1, and the inputs are sampled only at the capture edge. result, overflow and dz_trap change only at a completion and hold their value in between. Reset clears busy, done, result, overflow and dz_trap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; sampled only when idle |
| signed_mode | input | 1 | 1 = signed division, 0 = unsigned |
| y_hi | input | 32 | Upper half of the dividend |
| opnd_lo | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Saturated quotient word |
| overflow | output | 1 | Quotient was clamped |
| dz_trap | output | 1 | Last request had a zero divisor |

## Verification
The hardest situations to reach from the ports are requests that arrive at the boundaries of a running division. One case is a start pulse carrying a zero divisor and a flipped mode partway through the loop, which must be ignored. Another is a new start issued in the very cycle that done is high, which must be accepted. The bench drives both deliberately, with the second start placed on the same falling edge at which done is seen. It also applies the most-negative dividend against the divisors -1, 1, the most-negative word and the most-positive word, in addition to pseudorandom operands in both modes.

// File: rtl/ydiv_pkg.sv
package ydiv_pkg;
  // Context captured with a request and needed again at completion.
  typedef struct packed {
    logic sgn;   // signed mode
    logic neg;   // true quotient is negative
  } op_ctx_t;
endpackage

// File: rtl/ydiv_prep.sv
module ydiv_prep #(
  parameter int W = 32
) (
  input  logic           signed_mode,
  input  logic [W-1:0]   y_hi,
  input  logic [W-1:0]   opnd_lo,
  input  logic [W-1:0]   divisor,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           quo_neg,
  output logic           dvs_zero
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_raw;
  logic          dvd_sign;
  logic          dvs_sign;

  assign dvd_raw  = {y_hi, opnd_lo};
  assign dvd_sign = signed_mode & dvd_raw[DW-1];
  assign dvs_sign = signed_mode & divisor[W-1];

  // The most-negative values map onto themselves, which is the
  // correct unsigned magnitude.
  assign dvd_mag  = dvd_sign ? (~dvd_raw + DW'(1)) : dvd_raw;
  assign dvs_mag  = dvs_sign ? (~divisor + W'(1)) : divisor;
  assign quo_neg  = dvd_sign ^ dvs_sign;
  assign dvs_zero = (divisor == '0);
endmodule

// File: rtl/ydiv_core.sv
module ydiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [2*W-1:0] dvd_in,
  input  logic [W-1:0]   dvs_in,
  output logic [2*W-1:0] quo,
  output logic           last
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

  logic [W-1:0]  acc;      // partial remainder
  logic [DW-1:0] shreg;    // dividend bits out, quotient bits in
  logic [W-1:0]  dvs_r;
  logic [CW-1:0] step;
  logic          run;

  logic [W:0]    trial;
  logic [W+1:0]  diff;
  logic          fits;

  assign trial = {acc, shreg[DW-1]};
  assign diff  = {1'b0, trial} - {2'b00, dvs_r};
  assign fits  = ~diff[W+1];
  assign quo   = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      shreg <= '0;
      dvs_r <= '0;
      step  <= '0;
      run   <= 1'b0;
      last  <= 1'b0;
    end else begin
      last <= 1'b0;
      if (load) begin
        acc   <= '0;
        shreg <= dvd_in;
        dvs_r <= dvs_in;
        step  <= '0;
        run   <= 1'b1;
      end else if (run) begin
        acc   <= fits ? diff[W-1:0] : trial[W-1:0];
        shreg <= {shreg[DW-2:0], fits};
        step  <= step + CW'(1);
        if (step == LAST_STEP) begin
          run  <= 1'b0;
          last <= 1'b1;
        end
      end
    end
  end

  // Restoring division keeps the partial remainder below the divisor.
  p_rem_bound_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (acc < dvs_r));
endmodule

// File: rtl/ydiv_finish.sv
module ydiv_finish #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic           sgn,
  input  logic           neg,
  output logic [2*W-1:0] res,
  output logic           ovf
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] POS_LIM = (DW'(1) << (W - 1)) - DW'(1);
  localparam logic [DW-1:0] NEG_LIM = DW'(1) << (W - 1);
  localparam logic [W-1:0]  POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] low_signed;

  assign low_signed = neg ? (~quo_mag[W-1:0] + W'(1)) : quo_mag[W-1:0];

  always_comb begin
    if (!sgn) begin
      ovf = |quo_mag[DW-1:W];
      res = ovf ? '1 : {{W{1'b0}}, quo_mag[W-1:0]};
    end else begin
      ovf = neg ? (quo_mag > NEG_LIM) : (quo_mag > POS_LIM);
      res = ovf ? {{W{1'b1}}, (neg ? NEG_MIN : POS_MAX)}
                : {{W{1'b0}}, low_signed};
    end
  end
endmodule

// File: rtl/ydiv_sat_unit.sv
module ydiv_sat_unit #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   y_hi,
  input  logic [W-1:0]   opnd_lo,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic           overflow,
  output logic           dz_trap
);
  import ydiv_pkg::*;
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_mag;
  logic [W-1:0]  dvs_mag;
  logic          quo_neg;
  logic          dvs_zero;
  logic [DW-1:0] core_q;
  logic          core_last;
  logic [DW-1:0] fin_res;
  logic          fin_ovf;
  logic          accept;
  logic          run_go;
  op_ctx_t       ctx_q;

  assign accept = start & ~busy;
  assign run_go = accept & ~dvs_zero;

  ydiv_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .y_hi        (y_hi),
    .opnd_lo     (opnd_lo),
    .divisor     (divisor),
    .dvd_mag     (dvd_mag),
    .dvs_mag     (dvs_mag),
    .quo_neg     (quo_neg),
    .dvs_zero    (dvs_zero)
  );

  ydiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .load   (run_go),
    .dvd_in (dvd_mag),
    .dvs_in (dvs_mag),
    .quo    (core_q),
    .last   (core_last)
  );

  ydiv_finish #(.W(W)) u_fin (
    .quo_mag (core_q),
    .sgn     (ctx_q.sgn),
    .neg     (ctx_q.neg),
    .res     (fin_res),
    .ovf     (fin_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
      dz_trap  <= 1'b0;
      ctx_q    <= '0;
    end else begin
      done <= 1'b0;
      if (accept && dvs_zero) begin
        done     <= 1'b1;
        dz_trap  <= 1'b1;
        overflow <= 1'b0;
        result   <= '0;
      end else if (run_go) begin
        busy  <= 1'b1;
        ctx_q <= '{sgn: signed_mode, neg: quo_neg};
      end else if (busy && core_last) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        result   <= fin_res;
        overflow <= fin_ovf;
        dz_trap  <= 1'b0;
      end
    end
  end

  p_trap_clean_r2: assert property (@(posedge clk) disable iff (rst)
    dz_trap |-> (!overflow && result == '0));
  p_sat_upper_r5: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (result[DW-1:W] == '1));
  p_plain_upper_r1: assert property (@(posedge clk) disable iff (rst)
    !overflow |-> (result[DW-1:W] == '0));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(result) && $stable(overflow) && $stable(dz_trap)));
endmodule

// File: tb/ydiv_sat_unit_tb.sv
module ydiv_sat_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] y_hi = '0;
  logic [31:0] opnd_lo = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, overflow, dz_trap;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  ydiv_sat_unit #(.W(32)) u_dut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .y_hi(y_hi), .opnd_lo(opnd_lo), .divisor(divisor),
    .busy(busy), .done(done), .result(result),
    .overflow(overflow), .dz_trap(dz_trap)
  );

  // ---------------- reference model ----------------
  function automatic void ref_div(input logic [31:0] y, input logic [31:0] a,
                                  input logic [31:0] d, input logic sm,
                                  output logic [63:0] r, output logic ov,
                                  output string tag);
    logic [63:0] dvd;
    logic [63:0] uq;
    longint sd, sv, sq;
    dvd = {y, a};
    if (!sm) begin
      uq = dvd / {32'h0, d};
      if (uq > 64'h0000_0000_FFFF_FFFF) begin
        r = '1; ov = 1'b1; tag = "R3";
      end else begin
        r = {32'h0, uq[31:0]}; ov = 1'b0; tag = "R1";
      end
    end else if (dvd == 64'h8000_0000_0000_0000) begin
      ov = 1'b1; tag = "R6";
      r = {32'hFFFF_FFFF, (d[31] ? 32'h7FFF_FFFF : 32'h8000_0000)};
    end else begin
      sd = $signed(dvd);
      sv = $signed(d);
      sq = sd / sv;
      if (sq > 64'sd2147483647) begin
        r = {32'hFFFF_FFFF, 32'h7FFF_FFFF}; ov = 1'b1; tag = "R5";
      end else if (sq < -64'sd2147483648) begin
        r = {32'hFFFF_FFFF, 32'h8000_0000}; ov = 1'b1; tag = "R5";
      end else begin
        r = {32'h0, sq[31:0]}; ov = 1'b0; tag = "R4";
      end
    end
  endfunction

  logic        m_busy = 0, m_done = 0, m_ovf = 0, m_trap = 0;
  logic [63:0] m_res = '0;
  string       m_tag = "R8";
  int          m_cnt = 0;
  logic        cmp_en = 0;
  logic [63:0] p_res;
  logic        p_ovf;
  string       p_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = '0; m_ovf = 0; m_trap = 0;
      m_cnt = 0; m_tag = "R8"; cmp_en = 1;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        if (divisor == 32'h0) begin
          m_done = 1; m_trap = 1; m_ovf = 0; m_res = '0; m_tag = "R2";
        end else begin
          ref_div(y_hi, opnd_lo, divisor, signed_mode, p_res, p_ovf, p_tag);
          m_busy = 1; m_cnt = 65;
        end
      end else if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res; m_ovf = p_ovf;
          m_trap = 0; m_tag = p_tag;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      string t;
      t = m_done ? m_tag : "R8";
      chk("R7 busy", 64'(busy), 64'(m_busy));
      chk("R7 done", 64'(done), 64'(m_done));
      chk({t, " result"}, result, m_res);
      chk({t, " overflow"}, 64'(overflow), 64'(m_ovf));
      chk({t, " dz_trap"}, 64'(dz_trap), 64'(m_trap));
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [31:0] y, input logic [31:0] a,
                       input logic [31:0] d, input logic sm);
    y_hi = y; opnd_lo = a; divisor = d; signed_mode = sm; start = 1'b1;
  endtask

  task automatic wait_done();
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] y, input logic [31:0] a,
                        input logic [31:0] d, input logic sm);
    @(negedge clk);
    drive(y, a, d, sm);
    wait_done();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;                                  // R8 reset values compared
    repeat (3) @(negedge clk);

    run_op(32'h0, 32'd100, 32'd7, 1'b0);         // R1
    run_op(32'hFFFF_FFFE, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0); // R1 large
    run_op(32'h1, 32'h0, 32'h1, 1'b0);           // R3
    run_op(32'h5, 32'h0, 32'h5, 1'b0);           // R3 y == d
    run_op(32'h5, 32'h0, 32'h0, 1'b0);           // R2 unsigned
    run_op(32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1);   // R2 signed
    run_op(32'hFFFF_FFFF, -32'sd100, 32'd7, 1'b1);          // R4 -> -14
    run_op(32'h0, 32'd100, -32'sd7, 1'b1);                  // R4
    run_op(32'hFFFF_FFFF, -32'sd100, -32'sd7, 1'b1);        // R4 -> 14
    run_op(32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);      // R4 edge -2^31
    run_op(32'h1, 32'h0, 32'd1, 1'b1);           // R5 positive
    run_op(32'h1, 32'h0, -32'sd1, 1'b1);         // R5 negative
    run_op(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1'b1); // R6 d=-1
    run_op(32'h8000_0000, 32'h0, 32'h1, 1'b1);         // R6 d=1
    run_op(32'h8000_0000, 32'h0, 32'h8000_0000, 1'b1); // R6 d=min
    run_op(32'h8000_0000, 32'h0, 32'h7FFF_FFFF, 1'b1); // R6 d=max

    // R8: start with zero divisor and flipped mode while busy is ignored
    @(negedge clk);
    drive(32'h0, 32'd1000, 32'd3, 1'b0);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    drive(32'h7, 32'h9, 32'h0, 1'b1);
    @(negedge clk);
    start = 1'b0;
    signed_mode = 1'b1; divisor = 32'h0;
    while (!done) @(negedge clk);
    // R7/R8: new start accepted in the done cycle itself
    drive(32'h0, 32'd77, 32'd11, 1'b0);
    wait_done();
    drive(32'h0, 32'd5, 32'h0, 1'b0);            // R2 back-to-back
    wait_done();
    drive(32'h0, 32'd9, 32'h0, 1'b1);            // R2 twice in a row
    wait_done();

    for (int i = 0; i < 48; i++) begin
      logic [31:0] ry, ra, rd;
      ry = $urandom();
      ra = $urandom();
      rd = $urandom();
      if (i % 3 == 0) ry = {24'h0, ry[7:0]};
      if (i % 3 == 1 && (i % 2) == 1) ry = {32{ra[31]}};
      if (rd == 32'h0) rd = 32'h1;
      run_op(ry, ra, rd, 1'(i % 2));
    end

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule